// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block works out the outcome of the relative branch instructions for a CPU with a 16-bit accumulator and a 24-bit program address. Each input beat carries everything one branch needs: the opcode byte, the four condition flags (negative, overflow, zero, carry), the emulation-mode bit, the address of the opcode and the operand bytes fetched after it. From these the block decides whether the branch is taken, computes the address of the next instruction and reports how many cycles the instruction costs.

Ten opcodes are handled. Eight short branches depend on a flag. One short branch and one long branch are always taken. Any other opcode is reported as not a branch. The block has one register stage. Input beats use a valid/ready handshake. The result is held on a valid/ready output until the consumer takes it. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `res_valid` is high and `res_ready` is low, the result stays stable and no new beat is accepted.

Top module: `cond_branch_unit`

## Requirements
- R1: Exactly the opcodes 0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0, 0xF0, 0x80 and 0x82 are branches. Any other opcode gives `res_not_branch`=1, `res_taken`=0, `res_next_pc`=0 and `res_cycles`=0.
- R2: A flag-conditional opcode has the form `ffp10000`. Bits [7:6] select the flag: 00 selects N, 01 selects V, 10 selects C and 11 selects Z. Bit 5 gives the flag value that makes the branch taken.
- R3: A taken short branch (conditional or always) gives `res_next_pc` = `in_pc` + 2 + the operand low byte sign-extended from 8 bits.
- R4: A conditional branch that is not taken gives `res_next_pc` = `in_pc` + 2 and applies no displacement.
- R5: Opcode 0x80 is always taken, and its cycle count is 3 plus 1 when `in_emu` is 1.
- R6: Opcode 0x82 is always taken. It uses a 16-bit displacement {`in_op_hi`,`in_op_lo`} (low byte first in memory), sign-extended, so `res_next_pc` = `in_pc` + 3 + displacement. Its cycle count is 4 whatever the value of `in_emu`.
- R7: A conditional branch costs 2 cycles, plus 1 when taken, plus 1 more when `in_emu` is 1.
- R8: All address arithmetic is 24 bits wide and wraps modulo 2^24.
- R9: A beat accepted on one edge shows its result with `res_valid`=1 right after the next edge.
- R10: `in_ready` = !`res_valid` || `res_ready`. While `res_valid` is high and `res_ready` is low, all result outputs stay stable.
- R11: After reset, `res_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_opcode | input | 8 | Opcode byte |
| in_flag_n | input | 1 | Negative flag |
| in_flag_v | input | 1 | Overflow flag |
| in_flag_z | input | 1 | Zero flag |
| in_flag_c | input | 1 | Carry flag |
| in_emu | input | 1 | Emulation-mode bit |
| in_pc | input | 24 | Address of the opcode byte |
| in_op_lo | input | 8 | First operand byte |
| in_op_hi | input | 8 | Second operand byte (long branch only) |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_taken | output | 1 | Branch taken |
| res_not_branch | output | 1 | Opcode is not a branch |
| res_next_pc | output | 24 | Address of the next instruction |
| res_cycles | output | 4 | Cycle count of the instruction |

## Verification
Every result appears exactly one edge after its beat is accepted. The bench therefore drives a beat on a falling edge, drops `in_valid` on the following falling edge, and compares the outputs at that point against a model written from the requirements. For back-pressure the bench holds `res_ready` low over several edges. At each falling edge it checks that the result is stable and that `in_ready` is low. It then checks that a waiting beat appears one edge after `res_ready` rises. Random beats mix all ten opcodes with arbitrary other opcode bytes, flags, addresses near the wrap point and operand bytes.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_COND   = 2'd1,
    KIND_SHORT  = 2'd2,
    KIND_LONG   = 2'd3
  } br_kind_e;

  // flag selector encoded in opcode bits [7:6]
  typedef enum logic [1:0] {
    FSEL_N = 2'd0,
    FSEL_V = 2'd1,
    FSEL_C = 2'd2,
    FSEL_Z = 2'd3
  } flag_sel_e;

  typedef struct packed {
    br_kind_e  kind;
    flag_sel_e fsel;
    logic      want;
  } br_dec_t;

  localparam logic [7:0] OPC_ALWAYS_SHORT = 8'h80;
  localparam logic [7:0] OPC_ALWAYS_LONG  = 8'h82;
  localparam logic [4:0] COND_TAIL        = 5'b10000;

  localparam int unsigned SHORT_LEN = 2;
  localparam int unsigned LONG_LEN  = 3;

endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       flag_n,
  input  logic       flag_v,
  input  logic       flag_z,
  input  logic       flag_c,
  output br_dec_t    dec,
  output logic       taken
);

  logic is_cond;
  logic sel_flag;

  assign is_cond = (opcode[4:0] == COND_TAIL);

  always_comb begin
    dec.fsel = flag_sel_e'(opcode[7:6]);
    dec.want = opcode[5];
    if (is_cond)
      dec.kind = KIND_COND;
    else if (opcode == OPC_ALWAYS_SHORT)
      dec.kind = KIND_SHORT;
    else if (opcode == OPC_ALWAYS_LONG)
      dec.kind = KIND_LONG;
    else
      dec.kind = KIND_NONE;
  end

  always_comb begin
    unique case (dec.fsel)
      FSEL_N:  sel_flag = flag_n;
      FSEL_V:  sel_flag = flag_v;
      FSEL_C:  sel_flag = flag_c;
      default: sel_flag = flag_z;
    endcase
  end

  always_comb begin
    unique case (dec.kind)
      KIND_COND:  taken = (sel_flag == dec.want);
      KIND_SHORT: taken = 1'b1;
      KIND_LONG:  taken = 1'b1;
      default:    taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbu_target.sv
module cbu_target
  import cbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [7:0]        op_lo,
  input  logic [7:0]        op_hi,
  input  br_kind_e          kind,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_pc
);

  localparam int unsigned EXT8  = ADDR_W - 8;
  localparam int unsigned EXT16 = ADDR_W - 16;

  logic [ADDR_W-1:0] disp8;
  logic [ADDR_W-1:0] disp16;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] disp;

  assign disp8  = {{EXT8{op_lo[7]}}, op_lo};
  assign disp16 = {{EXT16{op_hi[7]}}, op_hi, op_lo};

  always_comb begin
    step = ADDR_W'(SHORT_LEN);
    disp = '0;
    unique case (kind)
      KIND_LONG: begin
        step = ADDR_W'(LONG_LEN);
        disp = disp16;
      end
      KIND_SHORT: disp = disp8;
      KIND_COND:  disp = taken ? disp8 : '0;
      default:    step = '0;
    endcase
  end

  always_comb begin
    if (kind == KIND_NONE)
      next_pc = '0;
    else
      next_pc = pc + step + disp;
  end

endmodule

// File: rtl/cbu_cycles.sv
module cbu_cycles
  import cbu_pkg::*;
#(
  parameter int unsigned CYC_W = 4
) (
  input  br_kind_e         kind,
  input  logic             taken,
  input  logic             emu,
  output logic [CYC_W-1:0] cycles
);

  localparam logic [CYC_W-1:0] BASE_COND  = CYC_W'(2);
  localparam logic [CYC_W-1:0] BASE_SHORT = CYC_W'(3);
  localparam logic [CYC_W-1:0] BASE_LONG  = CYC_W'(4);

  logic [CYC_W-1:0] emu_add;
  logic [CYC_W-1:0] take_add;

  assign emu_add  = CYC_W'(emu);
  assign take_add = CYC_W'(taken);

  always_comb begin
    unique case (kind)
      KIND_COND:  cycles = BASE_COND + take_add + emu_add;
      KIND_SHORT: cycles = BASE_SHORT + emu_add;
      KIND_LONG:  cycles = BASE_LONG;
      default:    cycles = '0;
    endcase
  end

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic              in_flag_n,
  input  logic              in_flag_v,
  input  logic              in_flag_z,
  input  logic              in_flag_c,
  input  logic              in_emu,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [7:0]        in_op_lo,
  input  logic [7:0]        in_op_hi,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_taken,
  output logic              res_not_branch,
  output logic [ADDR_W-1:0] res_next_pc,
  output logic [CYC_W-1:0]  res_cycles
);

  br_dec_t           dec;
  logic              taken_c;
  logic [ADDR_W-1:0] next_c;
  logic [CYC_W-1:0]  cyc_c;
  logic              accept;

  cbu_decode u_dec (
    .opcode (in_opcode),
    .flag_n (in_flag_n),
    .flag_v (in_flag_v),
    .flag_z (in_flag_z),
    .flag_c (in_flag_c),
    .dec    (dec),
    .taken  (taken_c)
  );

  cbu_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc      (in_pc),
    .op_lo   (in_op_lo),
    .op_hi   (in_op_hi),
    .kind    (dec.kind),
    .taken   (taken_c),
    .next_pc (next_c)
  );

  cbu_cycles #(.CYC_W(CYC_W)) u_cyc (
    .kind   (dec.kind),
    .taken  (taken_c),
    .emu    (in_emu),
    .cycles (cyc_c)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_taken      <= 1'b0;
      res_not_branch <= 1'b0;
      res_next_pc    <= '0;
      res_cycles     <= '0;
    end else if (accept) begin
      res_valid      <= 1'b1;
      res_taken      <= taken_c;
      res_not_branch <= (dec.kind == KIND_NONE);
      res_next_pc    <= next_c;
      res_cycles     <= cyc_c;
    end else if (res_ready) begin
      res_valid      <= 1'b0;
    end
  end

endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CYC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_taken,
  input logic              res_not_branch,
  input logic [ADDR_W-1:0] res_next_pc,
  input logic [CYC_W-1:0]  res_cycles
);

  AST_NOT_BRANCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_not_branch |-> !res_taken && res_next_pc == '0 && res_cycles == '0); // R1

  AST_UNTAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_not_branch && !res_taken |-> res_cycles >= CYC_W'(2) && res_cycles <= CYC_W'(3)); // R7

  AST_BRANCH_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_not_branch |-> res_cycles >= CYC_W'(2) && res_cycles <= CYC_W'(4)); // R7

  AST_ONE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_next_pc) && $stable(res_cycles)
      && $stable(res_taken) && $stable(res_not_branch)); // R10

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> in_ready); // R10

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !$past(rst_n) |-> !res_valid); // R11

endmodule

bind cond_branch_unit cbu_checker #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_taken      (res_taken),
  .res_not_branch (res_not_branch),
  .res_next_pc    (res_next_pc),
  .res_cycles     (res_cycles)
);

// File: tb/tb_cond_branch_unit.sv
`timescale 1ns/1ps
module tb_cond_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic        in_flag_n = 1'b0, in_flag_v = 1'b0, in_flag_z = 1'b0, in_flag_c = 1'b0;
  logic        in_emu = 1'b0;
  logic [23:0] in_pc = '0;
  logic [7:0]  in_op_lo = '0, in_op_hi = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_taken, res_not_branch;
  logic [23:0] res_next_pc;
  logic [3:0]  res_cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cond_branch_unit dut (.*);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input [7:0] op, input n, v, z, c, e, input [23:0] pc,
                       input [7:0] lo, hi, output nb, tk, output [23:0] nx, output [3:0] cy);
    logic f;
    nb = 0; tk = 0; nx = 0; cy = 0;
    if (op[4:0] == 5'h10) begin
      case (op[7:6])
        2'd0: f = n;
        2'd1: f = v;
        2'd2: f = c;
        default: f = z;
      endcase
      tk = (f == op[5]);
      nx = pc + 24'd2 + (tk ? {{16{lo[7]}}, lo} : 24'd0);
      cy = 4'd2 + {3'd0, tk} + {3'd0, e};
    end else if (op == 8'h80) begin
      tk = 1; nx = pc + 24'd2 + {{16{lo[7]}}, lo}; cy = 4'd3 + {3'd0, e};
    end else if (op == 8'h82) begin
      tk = 1; nx = pc + 24'd3 + {{8{hi[7]}}, hi, lo}; cy = 4'd4;
    end else nb = 1;
  endtask

  task automatic drive(input [7:0] op, input [3:0] nvzc, input e, input [23:0] pc, input [7:0] lo, hi);
    in_opcode = op; {in_flag_n, in_flag_v, in_flag_z, in_flag_c} = nvzc;
    in_emu = e; in_pc = pc; in_op_lo = lo; in_op_hi = hi;
  endtask

  task automatic run(input string req, input [7:0] op, input [3:0] nvzc, input e,
                     input [23:0] pc, input [7:0] lo, hi);
    logic nb, tk; logic [23:0] nx; logic [3:0] cy;
    model(op, nvzc[3], nvzc[2], nvzc[1], nvzc[0], e, pc, lo, hi, nb, tk, nx, cy);
    @(negedge clk);
    drive(op, nvzc, e, pc, lo, hi);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "valid", res_valid, 1);
    check(req, "not_branch", res_not_branch, nb);
    check(req, "taken", res_taken, tk);
    check(req, "next_pc", res_next_pc, nx);
    check(req, "cycles", res_cycles, cy);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [10] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0, 8'h80, 8'h82};
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    check("R11", "res_valid after reset", res_valid, 0);
    check("R11", "in_ready after reset", in_ready, 1);
    rst_n = 1'b1;

    // R1 non-branch opcodes
    run("R1", 8'h00, 4'hF, 1, 24'h123456, 8'h7F, 8'h7F);
    run("R1", 8'h81, 4'hF, 0, 24'h000100, 8'h01, 8'h00);
    run("R1", 8'h11, 4'h0, 0, 24'h000100, 8'h01, 8'h00);
    // R2 each flag, both polarities: nvzc bit order
    run("R2", 8'h10, 4'b0000, 0, 24'h001000, 8'h10, 8'h00);
    run("R2", 8'h30, 4'b0000, 0, 24'h001000, 8'h10, 8'h00);
    run("R2", 8'h70, 4'b0100, 0, 24'h001000, 8'h10, 8'h00);
    run("R2", 8'h90, 4'b0001, 1, 24'h001000, 8'h10, 8'h00);
    run("R2", 8'hB0, 4'b0001, 1, 24'h001000, 8'h10, 8'h00);
    run("R2", 8'hF0, 4'b0010, 0, 24'h001000, 8'h10, 8'h00);
    run("R2", 8'hD0, 4'b0010, 0, 24'h001000, 8'h10, 8'h00);
    // R3 negative displacement, R4 not taken
    run("R3", 8'h50, 4'b0000, 0, 24'h002000, 8'h80, 8'hAA);
    run("R4", 8'h50, 4'b0100, 1, 24'h002000, 8'h80, 8'hAA);
    // R5 always short with emu
    run("R5", 8'h80, 4'b0000, 1, 24'h003000, 8'hFE, 8'h00);
    // R6 long branch ignores emu, negative 16-bit
    run("R6", 8'h82, 4'b1111, 1, 24'h004000, 8'h00, 8'h80);
    run("R6", 8'h82, 4'b0000, 0, 24'h004000, 8'hFF, 8'h7F);
    // R8 wrap both directions
    run("R8", 8'h80, 4'b0000, 0, 24'hFFFFFE, 8'h05, 8'h00);
    run("R8", 8'h82, 4'b0000, 0, 24'h000001, 8'h00, 8'hF0);
    // R7 taken emu cost
    run("R7", 8'hF0, 4'b0010, 1, 24'h005000, 8'h01, 8'h00);

    // R10 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    run("R10", 8'h80, 4'b0000, 0, 24'h010000, 8'h04, 8'h00);
    drive(8'h82, 4'b0000, 0, 24'h020000, 8'h10, 8'h00);
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", "in_ready stalled", in_ready, 0);
      check("R10", "held next_pc", res_next_pc, 24'h010006);
      check("R10", "held cycles", res_cycles, 3);
    end
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "waiting beat next_pc", res_next_pc, 24'h020013);
    check("R10", "waiting beat valid", res_valid, 1);
    @(negedge clk);
    check("R10", "drained valid", res_valid, 0);
    check("R10", "ready when empty", in_ready, 1);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      op = ($urandom % 4 == 0) ? 8'($urandom) : ops[$urandom % 10];
      run(op == 8'h82 ? "R6" : (op == 8'h80 ? "R5" : "R3"), op, 4'($urandom), 1'($urandom),
          ($urandom % 3 == 0) ? 24'hFFFF00 | 24'($urandom % 256) : 24'($urandom),
          8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule